// File: doc/BRIEF.md
# Comparator Reference Trim Calibration Sequencer

This block runs a foreground calibration of the reference trims of a fifteen-comparator flash or binary-search quantiser. After a start command it takes the comparators one at a time, in index order. For each comparator it chooses the test level to inject and applies trim code 0. It then raises the trim code by one step at a time. At every step it waits a programmable settle time before it samples the comparator decision. The first code whose decision differs from the decision at code 0 is frozen and written to a per-comparator trim register. A comparator that never changes polarity is given the top code and a saturation flag.

Two sweep modes share the same rule. In reference mode, comparator i is driven with its own test level, which is i − 7 LSB. In offset mode, every comparator sees the common-mode level. The trim codes run from 0 to 16. Each code is one quarter LSB, and code 8 is the untrimmed reference, so the range covers −2 to +2 LSB. The stored codes and flags stay in place until reset or until the next run starts. Any entry can be read back by index.

Top module: `cmp_trim_cal`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0, `trim_code_o` and `cmp_idx_o` are 0, every saturation flag is 0, and every stored code reads back as 0.
- R2: During a run the comparators are visited in the order 0, 1, … 14. For each comparator the applied trim code starts at 0 and rises by exactly 1 per step, never beyond 16.
- R3: The test level select `inject_sel_o` is encoded as level = code − 7 LSB, so code 7 is common mode. In reference mode (`mode_i` = 0 at start) it equals `cmp_idx_o`. In offset mode (`mode_i` = 1) it is 7 for every comparator.
- R4: The stored code of a comparator is the lowest code k ≥ 1 whose sampled decision differs from the decision sampled at code 0.
- R5: If no code up to 16 gives a differing decision, code 16 is stored and that comparator's saturation flag (bit i of `sat_o`) is set. Otherwise the flag is 0.
- R6: Every trim code stays applied for exactly `settle_i` + 1 clock cycles. The decision is sampled at the clock edge that ends that window. `settle_i` is captured at start.
- R7: `busy_o` rises on the cycle after an accepted start. When the last comparator is stored, `busy_o` falls and `done_o` rises on the same edge. `done_o` then stays high until the next start.
- R8: A start while busy is ignored. The run continues with the mode and settle value it began with.
- R9: Reading index i returns entry i. Indices of 15 or more return code 0 with a clear flag. A new run clears all entries when it starts, and the entries do not change while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a calibration run (accepted only when idle) |
| mode_i | input | 1 | 0 = reference sweep, 1 = offset sweep at common mode |
| settle_i | input | 8 | Settle cycles per trim step |
| dec_i | input | 1 | Decision of the comparator under calibration |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Last run completed |
| cmp_idx_o | output | 4 | Comparator under calibration |
| trim_code_o | output | 5 | Trim code applied to that comparator |
| inject_sel_o | output | 4 | Injected test level select (level = code − 7 LSB) |
| sat_o | output | 15 | Per-comparator saturation flags |
| rd_idx_i | input | 4 | Readback index |
| rd_code_o | output | 5 | Stored trim code of the indexed entry |
| rd_sat_o | output | 1 | Saturation flag of the indexed entry |

## Verification
The bench builds the block with its default values: 15 comparators, 17 trim codes, an 8-bit settle count, and combinational readback. Its comparator model delays the ideal decision by three cycles, so any step that is sampled early would read the decision from the previous code. Settle values from 3 to 12 keep the model correct and let the bench measure the hold time of each code. Hidden per-comparator offsets of ±10 quarter-LSB put a flip at code 0, at code 16, or at no code at all. The bench also runs offset-mode sweeps, which saturate for the comparators far from mid-scale.

// File: rtl/cmp_cal_pkg.sv
package cmp_cal_pkg;

   typedef enum logic [0:0] {
      SWP_IDLE   = 1'b0,
      SWP_SETTLE = 1'b1
   } sweep_state_e;

   // index of the comparator whose own level is common mode
   function automatic int mid_index(input int num_cmp);
      return (num_cmp - 1) / 2;
   endfunction

endpackage

// File: rtl/trim_settle_timer.sv
module trim_settle_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_i,
   input  logic             reload_i,
   input  logic [CNT_W-1:0] period_i,
   output logic             expired_o
);

   logic [CNT_W-1:0] per_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_q <= '0;
         cnt_q <= '0;
      end else if (arm_i) begin
         per_q <= period_i;
         cnt_q <= period_i;
      end else if (reload_i) begin
         cnt_q <= per_q;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/trim_sweep_fsm.sv
module trim_sweep_fsm
   import cmp_cal_pkg::*;
#(
   parameter int NUM_CMP    = 15,
   parameter int TRIM_STEPS = 17,
   parameter int IDX_W      = 4,
   parameter int TRIM_W     = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              mode_i,
   input  logic              expired_i,
   input  logic              dec_i,
   output logic              arm_o,
   output logic              reload_o,
   output logic              clr_o,
   output logic              we_o,
   output logic              wsat_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic [TRIM_W-1:0] code_o,
   output logic [IDX_W-1:0]  sel_o,
   output logic              busy_o,
   output logic              done_o
);

   localparam int TOP  = TRIM_STEPS - 1;
   localparam int LAST = NUM_CMP - 1;
   localparam int MID  = mid_index(NUM_CMP);

   sweep_state_e      state_q;
   logic [IDX_W-1:0]  idx_q;
   logic [TRIM_W-1:0] code_q;
   logic              mode_q;
   logic              ref_pol_q;
   logic              done_q;

   logic accept, sample, first_step, flip, at_top, finish, last_cmp;

   always_comb begin
      accept     = (state_q == SWP_IDLE) && start_i;
      sample     = (state_q == SWP_SETTLE) && expired_i;
      first_step = (code_q == '0);
      at_top     = (code_q == TRIM_W'(TOP));
      flip       = sample && !first_step && (dec_i != ref_pol_q);
      finish     = sample && !first_step && ((dec_i != ref_pol_q) || at_top);
      last_cmp   = (idx_q == IDX_W'(LAST));
   end

   assign arm_o    = accept;
   assign clr_o    = accept;
   assign reload_o = sample && !(finish && last_cmp);
   assign we_o     = finish;
   assign wsat_o   = !flip;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SWP_IDLE;
         idx_q     <= '0;
         code_q    <= '0;
         mode_q    <= 1'b0;
         ref_pol_q <= 1'b0;
         done_q    <= 1'b0;
      end else begin
         case (state_q)
            SWP_IDLE: begin
               if (accept) begin
                  state_q <= SWP_SETTLE;
                  idx_q   <= '0;
                  code_q  <= '0;
                  mode_q  <= mode_i;
                  done_q  <= 1'b0;
               end
            end
            SWP_SETTLE: begin
               if (sample) begin
                  if (first_step) begin
                     ref_pol_q <= dec_i;
                     code_q    <= TRIM_W'(1);
                  end else if (finish) begin
                     code_q <= '0;
                     if (last_cmp) begin
                        state_q <= SWP_IDLE;
                        idx_q   <= '0;
                        done_q  <= 1'b1;
                     end else begin
                        idx_q <= idx_q + IDX_W'(1);
                     end
                  end else begin
                     code_q <= code_q + TRIM_W'(1);
                  end
               end
            end
            default: state_q <= SWP_IDLE;
         endcase
      end
   end

   assign idx_o  = idx_q;
   assign code_o = code_q;
   assign sel_o  = mode_q ? IDX_W'(MID) : idx_q;
   assign busy_o = (state_q == SWP_SETTLE);
   assign done_o = done_q;

endmodule

// File: rtl/trim_store.sv
module trim_store #(
   parameter int NUM_CMP = 15,
   parameter int IDX_W   = 4,
   parameter int TRIM_W  = 5,
   parameter bit RD_REG  = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr_i,
   input  logic               we_i,
   input  logic [IDX_W-1:0]   widx_i,
   input  logic [TRIM_W-1:0]  wcode_i,
   input  logic               wsat_i,
   input  logic [IDX_W-1:0]   rd_idx_i,
   output logic [TRIM_W-1:0]  rd_code_o,
   output logic               rd_sat_o,
   output logic [NUM_CMP-1:0] sat_o
);

   logic [NUM_CMP*TRIM_W-1:0] code_flat;
   logic [NUM_CMP-1:0]        sat_vec;

   for (genvar e = 0; e < NUM_CMP; e++) begin : g_ent
      logic [TRIM_W-1:0] c_q;
      logic              s_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            c_q <= '0;
            s_q <= 1'b0;
         end else if (clr_i) begin
            c_q <= '0;
            s_q <= 1'b0;
         end else if (we_i && (widx_i == IDX_W'(e))) begin
            c_q <= wcode_i;
            s_q <= wsat_i;
         end
      end
      assign code_flat[e*TRIM_W +: TRIM_W] = c_q;
      assign sat_vec[e] = s_q;
   end

   logic [TRIM_W-1:0] rd_code_c;
   logic              rd_sat_c;

   always_comb begin
      rd_code_c = '0;
      rd_sat_c  = 1'b0;
      for (int e = 0; e < NUM_CMP; e++) begin
         if (rd_idx_i == IDX_W'(e)) begin
            rd_code_c = code_flat[e*TRIM_W +: TRIM_W];
            rd_sat_c  = sat_vec[e];
         end
      end
   end

   if (RD_REG) begin : g_rd_reg
      logic [TRIM_W-1:0] rc_q;
      logic              rs_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rc_q <= '0;
            rs_q <= 1'b0;
         end else begin
            rc_q <= rd_code_c;
            rs_q <= rd_sat_c;
         end
      end
      assign rd_code_o = rc_q;
      assign rd_sat_o  = rs_q;
   end else begin : g_rd_comb
      assign rd_code_o = rd_code_c;
      assign rd_sat_o  = rd_sat_c;
   end

   assign sat_o = sat_vec;

endmodule

// File: rtl/cmp_trim_cal.sv
module cmp_trim_cal #(
   parameter int NUM_CMP    = 15,
   parameter int TRIM_STEPS = 17,
   parameter int SETTLE_W   = 8,
   parameter bit RD_REG     = 1'b0,
   localparam int IDX_W     = $clog2(NUM_CMP + 1),
   localparam int TRIM_W    = $clog2(TRIM_STEPS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                mode_i,
   input  logic [SETTLE_W-1:0] settle_i,
   input  logic                dec_i,
   output logic                busy_o,
   output logic                done_o,
   output logic [IDX_W-1:0]    cmp_idx_o,
   output logic [TRIM_W-1:0]   trim_code_o,
   output logic [IDX_W-1:0]    inject_sel_o,
   output logic [NUM_CMP-1:0]  sat_o,
   input  logic [IDX_W-1:0]    rd_idx_i,
   output logic [TRIM_W-1:0]   rd_code_o,
   output logic                rd_sat_o
);

   if ((NUM_CMP < 3) || ((NUM_CMP % 2) == 0)) begin : g_bad_num_cmp
      $error("NUM_CMP must be odd and at least 3");
   end
   if (TRIM_STEPS < 3) begin : g_bad_trim_steps
      $error("TRIM_STEPS must be at least 3");
   end
   if (SETTLE_W < 1) begin : g_bad_settle_w
      $error("SETTLE_W must be at least 1");
   end

   logic arm, reload, expired, clr, we, wsat;

   trim_settle_timer #(.CNT_W(SETTLE_W)) timer_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm_i     (arm),
      .reload_i  (reload),
      .period_i  (settle_i),
      .expired_o (expired)
   );

   trim_sweep_fsm #(
      .NUM_CMP    (NUM_CMP),
      .TRIM_STEPS (TRIM_STEPS),
      .IDX_W      (IDX_W),
      .TRIM_W     (TRIM_W)
   ) fsm_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .mode_i    (mode_i),
      .expired_i (expired),
      .dec_i     (dec_i),
      .arm_o     (arm),
      .reload_o  (reload),
      .clr_o     (clr),
      .we_o      (we),
      .wsat_o    (wsat),
      .idx_o     (cmp_idx_o),
      .code_o    (trim_code_o),
      .sel_o     (inject_sel_o),
      .busy_o    (busy_o),
      .done_o    (done_o)
   );

   trim_store #(
      .NUM_CMP (NUM_CMP),
      .IDX_W   (IDX_W),
      .TRIM_W  (TRIM_W),
      .RD_REG  (RD_REG)
   ) store_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (clr),
      .we_i      (we),
      .widx_i    (cmp_idx_o),
      .wcode_i   (trim_code_o),
      .wsat_i    (wsat),
      .rd_idx_i  (rd_idx_i),
      .rd_code_o (rd_code_o),
      .rd_sat_o  (rd_sat_o),
      .sat_o     (sat_o)
   );

endmodule

// File: rtl/cmp_trim_cal_chk.sv
module cmp_trim_cal_chk #(
   parameter int NUM_CMP    = 15,
   parameter int TRIM_STEPS = 17,
   parameter int IDX_W      = 4,
   parameter int TRIM_W     = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start_i,
   input logic               busy_o,
   input logic               done_o,
   input logic [IDX_W-1:0]   cmp_idx_o,
   input logic [TRIM_W-1:0]  trim_code_o,
   input logic [IDX_W-1:0]   inject_sel_o,
   input logic [NUM_CMP-1:0] sat_o
);

   localparam int TOP  = TRIM_STEPS - 1;
   localparam int LAST = NUM_CMP - 1;
   localparam int MID  = (NUM_CMP - 1) / 2;

   assert_code_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (trim_code_o <= TRIM_W'(TOP)));

   assert_code_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o) && (cmp_idx_o == $past(cmp_idx_o)) &&
       (trim_code_o != $past(trim_code_o)))
      |-> (trim_code_o == $past(trim_code_o) + TRIM_W'(1)));

   assert_idx_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o) && (cmp_idx_o != $past(cmp_idx_o)))
      |-> ((cmp_idx_o == $past(cmp_idx_o) + IDX_W'(1)) && (trim_code_o == '0)));

   assert_sel_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> ((inject_sel_o == cmp_idx_o) || (inject_sel_o == IDX_W'(MID))));

   assert_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   assert_done_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $fell(busy_o));

   assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && (cmp_idx_o != IDX_W'(LAST))) |=> busy_o);

   assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !$past(busy_o)) |-> $stable(sat_o));

endmodule

bind cmp_trim_cal cmp_trim_cal_chk #(
   .NUM_CMP    (NUM_CMP),
   .TRIM_STEPS (TRIM_STEPS),
   .IDX_W      (IDX_W),
   .TRIM_W     (TRIM_W)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .busy_o       (busy_o),
   .done_o       (done_o),
   .cmp_idx_o    (cmp_idx_o),
   .trim_code_o  (trim_code_o),
   .inject_sel_o (inject_sel_o),
   .sat_o        (sat_o)
);

// File: tb/cmp_trim_cal_tb_top.sv
module cmp_trim_cal_tb_top;

   localparam int NC   = 15;
   localparam int TS   = 17;
   localparam int SW   = 8;
   localparam int IW   = 4;
   localparam int TW   = 5;
   localparam int MIDL = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          mode_i = 1'b0;
   logic [SW-1:0] settle_i = '0;
   logic          dec_i;
   logic          busy_o, done_o, rd_sat_o;
   logic [IW-1:0] cmp_idx_o, inject_sel_o;
   logic [TW-1:0] trim_code_o, rd_code_o;
   logic [NC-1:0] sat_o;
   logic [IW-1:0] rd_idx_i = '0;

   always #2 clk = ~clk;

   cmp_trim_cal dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
      .settle_i(settle_i), .dec_i(dec_i), .busy_o(busy_o), .done_o(done_o),
      .cmp_idx_o(cmp_idx_o), .trim_code_o(trim_code_o),
      .inject_sel_o(inject_sel_o), .sat_o(sat_o), .rd_idx_i(rd_idx_i),
      .rd_code_o(rd_code_o), .rd_sat_o(rd_sat_o)
   );

   // analog model: hidden offsets in quarter LSB, decision delayed 3 cycles
   int   offs [NC];
   logic d1 = 1'b0, d2 = 1'b0, d3 = 1'b0;

   function automatic logic ideal_dec(int idx, int sel, int code, int offv);
      return (4 * (sel - MIDL)) > (4 * (idx - MIDL) + offv + (code - 8));
   endfunction

   always @(posedge clk) begin
      d1 <= ideal_dec(int'(cmp_idx_o), int'(inject_sel_o), int'(trim_code_o),
                      (int'(cmp_idx_o) < NC) ? offs[int'(cmp_idx_o)] : 0);
      d2 <= d1;
      d3 <= d2;
   end
   assign dec_i = d3;

   // expected result: code + 100 * saturation
   function automatic int exp_result(int j, int sel, int offv);
      logic r0;
      r0 = ideal_dec(j, sel, 0, offv);
      for (int c = 1; c < TS; c++)
         if (ideal_dec(j, sel, c, offv) != r0) return c;
      return (TS - 1) + 100;
   endfunction

   int n_tests = 0;
   int n_fail  = 0;

   task automatic check(bit ok, string tag, int act, int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic run_cal(bit md, int st, bit restart_mid);
      int  pidx, pcode, hold, steps;
      bit  seq_ok, hold_ok, sel_ok, clr_ok;
      rd_idx_i = IW'(NC - 1);
      @(negedge clk);
      mode_i = md; settle_i = SW'(st); start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check(busy_o == 1'b1 && done_o == 1'b0, "R7 busy after start", busy_o, 1);
      clr_ok = (rd_code_o == '0) && (rd_sat_o == 1'b0);
      check(clr_ok, "R9 entry cleared at new run", rd_code_o, 0);
      pidx = 0; pcode = 0; hold = 1; steps = 0;
      seq_ok = 1; hold_ok = 1; sel_ok = 1;
      while (busy_o) begin
         if (int'(inject_sel_o) != (md ? MIDL : int'(cmp_idx_o))) sel_ok = 0;
         @(negedge clk);
         steps++;
         if (restart_mid && steps == 40) begin
            start_i = 1'b1; mode_i = ~md; settle_i = SW'(st + 7);
         end else if (restart_mid && steps == 41) begin
            start_i = 1'b0; mode_i = md; settle_i = SW'(st);
         end
         if (!busy_o) break;
         if (int'(cmp_idx_o) == pidx && int'(trim_code_o) == pcode) begin
            hold++;
         end else begin
            if (hold != st + 1) hold_ok = 0;
            if (!((int'(cmp_idx_o) == pidx && int'(trim_code_o) == pcode + 1) ||
                  (int'(cmp_idx_o) == pidx + 1 && trim_code_o == '0))) seq_ok = 0;
            if (int'(trim_code_o) > TS - 1) seq_ok = 0;
            pidx = int'(cmp_idx_o); pcode = int'(trim_code_o); hold = 1;
         end
      end
      check(seq_ok && pidx == NC - 1, "R2 index/code order", pidx, NC - 1);
      check(sel_ok, "R3 injected level select", int'(sel_ok), 1);
      check(hold_ok, "R6 settle hold per code", int'(hold_ok), 1);
      check(done_o == 1'b1, "R7 done at end", done_o, 1);
      for (int j = 0; j < NC; j++) begin
         int e, ec, es;
         e  = exp_result(j, md ? MIDL : j, offs[j]);
         ec = e % 100; es = e / 100;
         rd_idx_i = IW'(j);
         @(negedge clk);
         check(int'(rd_code_o) == ec, $sformatf("R4 code cmp %0d", j), rd_code_o, ec);
         check(rd_sat_o == es[0] && sat_o[j] == es[0],
               $sformatf("R5 sat cmp %0d", j), rd_sat_o, es);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog R7 actual busy=%0d expected done=1", busy_o);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int seed, st;
      seed = $urandom(32'd2024);
      for (int j = 0; j < NC; j++) offs[j] = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(busy_o == 0 && done_o == 0, "R1 busy/done reset", busy_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      rd_idx_i = IW'(3);
      @(negedge clk);
      check(sat_o == '0 && rd_code_o == '0 && trim_code_o == '0 && cmp_idx_o == '0,
            "R1 stored/applied codes reset", rd_code_o, 0);

      // directed: flip at code 0 (sat), flip at 16, never flips, mid, near bottom
      for (int j = 0; j < NC; j++) offs[j] = int'($urandom_range(12)) - 6;
      offs[0] = 8; offs[1] = -8; offs[2] = -9; offs[3] = 0; offs[4] = 7; offs[5] = 10;
      run_cal(1'b0, 3, 1'b0);

      // done holds while idle, flags unchanged (R7, R9)
      repeat (5) @(negedge clk);
      check(done_o == 1'b1 && busy_o == 1'b0, "R7 done held idle", done_o, 1);
      check(sat_o[0] && !sat_o[1] && sat_o[2], "R9 flags held idle", sat_o, 5);
      rd_idx_i = IW'(NC);
      @(negedge clk);
      check(rd_code_o == '0 && rd_sat_o == 1'b0, "R9 out-of-range read", rd_code_o, 0);

      // offset mode at common mode (R3)
      run_cal(1'b1, 4, 1'b0);

      // start while busy ignored (R8): results follow the original mode
      for (int j = 0; j < NC; j++) offs[j] = int'($urandom_range(20)) - 10;
      run_cal(1'b0, 5, 1'b1);
      check(done_o == 1'b1, "R8 run completes after ignored start", done_o, 1);

      // random runs
      for (int r = 0; r < 4; r++) begin
         for (int j = 0; j < NC; j++) offs[j] = int'($urandom_range(20)) - 10;
         st = 3 + int'($urandom_range(9));
         run_cal(1'($urandom_range(1)), st, 1'b0);
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule